// File: doc/BRIEF.md
# Multi-drop receive address filter

This block sits behind a 9-bit serial receiver. Each received byte arrives with a flag that marks it as an address or a data byte. The block decides which bytes reach the host as events. Three filter policies can be selected. The first passes only address bytes, so software can do the matching itself. The second and third compare each address byte with a programmed station address. After a match, they accept the data bytes that follow, up to the next address byte. The second policy also reports the matching address byte. The third reports only the data bytes.

Each event is a one-cycle pulse. It carries the byte, an address-byte flag and a new-frame flag. The new-frame flag marks the first data byte after a matching address. While filtering is switched off, or the policy field selects pass-through, every byte is delivered unfiltered. The frame-accept state is cleared on reset and whenever the effective policy changes. Software can therefore drop to pass-through in the middle of a frame, and later return to address-only mode to mute the receiver until the next address byte.

Top module: `mp_addr_filter`

## Requirements
- R1: With `mp_en` = 0, every received byte produces an event whatever `mp_mode` holds. `evt_is_addr` copies `rx_is_addr` and `evt_new_frame` is 0.
- R2: With `mp_en` = 1 and `mp_mode` = 2'b00, every received byte produces an event and `evt_new_frame` is 0.
- R3: With `mp_en` = 1 and `mp_mode` = 2'b01, every address byte produces an event with `evt_is_addr` = 1, and data bytes produce none.
- R4: With `mp_mode` = 2'b10, an address byte equal to `station_addr` produces an event with `evt_is_addr` = 1 and opens the frame. Every data byte that follows, up to the next address byte, produces an event.
- R5: The first data byte of an accepted frame has `evt_new_frame` = 1. Later data bytes of the same frame have 0.
- R6: With `mp_mode` = 2'b10 or 2'b11, an address byte that differs from `station_addr` produces no event, and the data bytes after it produce none until a matching address byte arrives.
- R7: A matching address byte that arrives inside an open frame keeps the frame open, and the data byte after it again has `evt_new_frame` = 1.
- R8: With `mp_mode` = 2'b11, address bytes never produce an event, and data bytes are filtered exactly as in 2'b10.
- R9: Changing the effective policy (the mode field, or `mp_en`, where `mp_en` = 0 counts as 2'b00) closes any open frame. Data bytes that follow are dropped until a new matching address byte arrives.
- R10: An event appears exactly one clock after the byte's `rx_valid` cycle, lasts one cycle, and `evt_valid` is 0 in the cycle after any cycle without `rx_valid`.
- R11: During and after reset `evt_valid` is 0 and no frame is open. A data byte in 2'b10 mode before any address byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mp_en | input | 1 | Enables address filtering |
| mp_mode | input | 2 | Filter policy: 00 pass, 01 address only, 10 match with address events, 11 match data only |
| station_addr | input | DATA_W | Station address compared with address bytes |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | DATA_W | Received byte |
| rx_is_addr | input | 1 | The received byte is an address byte (ninth bit) |
| evt_valid | output | 1 | One-cycle event pulse |
| evt_byte | output | DATA_W | Byte delivered with the event |
| evt_is_addr | output | 1 | The event byte is an address byte (a new frame begins) |
| evt_new_frame | output | 1 | The event byte is the first data byte of an accepted frame |

## Verification
The hardest states to reach from the ports are those where the accept state and the pending new-frame marker interact with a policy change. Examples are a rematch inside an open frame with no data byte in between, and a mode switch in the same cycle as a data byte. Directed sequences build these states on purpose. A long random phase then mixes matching and non-matching address bytes with idle cycles and occasional policy and enable changes. A bench model of the requirements tracks the expected frame state on every cycle.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

   typedef enum logic [1:0] {
      MPF_PASS       = 2'b00,
      MPF_ADDR_ONLY  = 2'b01,
      MPF_MATCH_ALL  = 2'b10,
      MPF_MATCH_DATA = 2'b11
   } mpf_mode_e;

   typedef struct packed {
      logic vld;
      logic is_addr;
      logic new_frame;
   } mpf_flags_t;

endpackage

// File: rtl/mpf_addr_cmp.sv
module mpf_addr_cmp #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] station_addr,
   output logic              addr_match
);
   always_comb addr_match = (rx_byte == station_addr);
endmodule

// File: rtl/mpf_frame_tracker.sv
module mpf_frame_tracker
   import mpf_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  mpf_mode_e eff_mode,
   input  logic      rx_valid,
   input  logic      rx_is_addr,
   input  logic      addr_match,
   output logic      acc_now,
   output logic      pend_now
);
   mpf_mode_e mode_q;
   logic      acc_q, pend_q, acc_d, pend_d;
   logic      cfg_chg, filt;

   always_comb begin
      cfg_chg  = (mode_q != eff_mode);
      filt     = eff_mode[1];
      acc_now  = acc_q & ~cfg_chg;
      pend_now = pend_q & ~cfg_chg;
      acc_d    = acc_now;
      pend_d   = pend_now;
      if (rx_valid && filt) begin
         if (rx_is_addr) begin
            acc_d  = addr_match;
            pend_d = addr_match;
         end else if (acc_now) begin
            pend_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MPF_PASS;
         acc_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         mode_q <= eff_mode;
         acc_q  <= acc_d;
         pend_q <= pend_d;
      end
   end

   // R6
   mismatch_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && eff_mode[1] && rx_is_addr && !addr_match) |=> !acc_q);

   // R5
   pend_needs_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> acc_q);

endmodule

// File: rtl/mpf_event_gen.sv
module mpf_event_gen
   import mpf_pkg::*;
(
   input  mpf_mode_e  eff_mode,
   input  logic       rx_valid,
   input  logic       rx_is_addr,
   input  logic       addr_match,
   input  logic       acc_now,
   input  logic       pend_now,
   output mpf_flags_t flags
);
   always_comb begin
      flags.is_addr = rx_is_addr;
      unique case (eff_mode)
         MPF_PASS:       flags.vld = rx_valid;
         MPF_ADDR_ONLY:  flags.vld = rx_valid & rx_is_addr;
         MPF_MATCH_ALL:  flags.vld = rx_valid & (rx_is_addr ? addr_match : acc_now);
         MPF_MATCH_DATA: flags.vld = rx_valid & ~rx_is_addr & acc_now;
         default:        flags.vld = 1'b0;
      endcase
      flags.new_frame = flags.vld & eff_mode[1] & ~rx_is_addr & pend_now;
   end
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
   import mpf_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mp_en,
   input  logic [1:0]        mp_mode,
   input  logic [DATA_W-1:0] station_addr,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_is_addr,
   output logic              evt_valid,
   output logic [DATA_W-1:0] evt_byte,
   output logic              evt_is_addr,
   output logic              evt_new_frame
);
   if (DATA_W < 1) begin : g_bad_width
      $error("mp_addr_filter: DATA_W must be at least 1");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("mp_addr_filter: OUT_REG must be 0 or 1");
   end

   mpf_mode_e  eff_mode;
   logic       addr_match, acc_now, pend_now;
   mpf_flags_t flags;

   always_comb eff_mode = mpf_mode_e'(mp_en ? mp_mode : 2'b00);

   mpf_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
      .rx_byte      (rx_byte),
      .station_addr (station_addr),
      .addr_match   (addr_match)
   );

   mpf_frame_tracker u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .eff_mode   (eff_mode),
      .rx_valid   (rx_valid),
      .rx_is_addr (rx_is_addr),
      .addr_match (addr_match),
      .acc_now    (acc_now),
      .pend_now   (pend_now)
   );

   mpf_event_gen u_evt (
      .eff_mode   (eff_mode),
      .rx_valid   (rx_valid),
      .rx_is_addr (rx_is_addr),
      .addr_match (addr_match),
      .acc_now    (acc_now),
      .pend_now   (pend_now),
      .flags      (flags)
   );

   if (OUT_REG == 1) begin : g_out_reg
      mpf_flags_t       flags_q;
      logic [DATA_W-1:0] byte_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flags_q <= '0;
            byte_q  <= '0;
         end else begin
            flags_q <= flags;
            if (flags.vld) byte_q <= rx_byte;
         end
      end

      always_comb begin
         evt_valid     = flags_q.vld;
         evt_is_addr   = flags_q.is_addr;
         evt_new_frame = flags_q.new_frame;
         evt_byte      = byte_q;
      end

      // R1
      bypass_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rx_valid && !mp_en) |=> (evt_valid && !evt_new_frame));

      // R3
      addr_only_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rx_valid && mp_en && mp_mode == 2'b01 && !rx_is_addr) |=> !evt_valid);

      // R8
      data_only_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rx_valid && mp_en && mp_mode == 2'b11 && rx_is_addr) |=> !evt_valid);

      // R10
      idle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rx_valid |=> !evt_valid);
   end else begin : g_out_comb
      always_comb begin
         evt_valid     = flags.vld;
         evt_is_addr   = flags.is_addr;
         evt_new_frame = flags.new_frame;
         evt_byte      = rx_byte;
      end
   end

   // R5
   new_frame_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_new_frame |-> (evt_valid && !evt_is_addr));

endmodule

// File: tb/mp_addr_filter_test.sv
module mp_addr_filter_test;
   localparam int W = 8;
   localparam logic [W-1:0] STA = 8'h5A;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mp_en = 1'b0;
   logic [1:0]   mp_mode = 2'b00;
   logic [W-1:0] station_addr = STA;
   logic         rx_valid = 1'b0;
   logic [W-1:0] rx_byte = '0;
   logic         rx_is_addr = 1'b0;
   logic         evt_valid, evt_is_addr, evt_new_frame;
   logic [W-1:0] evt_byte;

   int  vectors = 0;
   int  fails = 0;
   bit  done = 1'b0;

   logic [1:0] m_prev = 2'b00;
   bit         m_acc = 1'b0, m_pend = 1'b0;

   always #2 clk = ~clk;

   mp_addr_filter #(.DATA_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .mp_en(mp_en), .mp_mode(mp_mode),
      .station_addr(station_addr), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_is_addr(rx_is_addr), .evt_valid(evt_valid), .evt_byte(evt_byte),
      .evt_is_addr(evt_is_addr), .evt_new_frame(evt_new_frame)
   );

   // Requirement model: returns {valid, new_frame} and advances frame state.
   function automatic logic [1:0] model(input bit en, input logic [1:0] md,
                                        input bit v, input bit ia,
                                        input logic [W-1:0] b);
      logic [1:0] eff;
      bit ev, nf;
      eff = en ? md : 2'b00;
      if (eff != m_prev) begin m_acc = 0; m_pend = 0; end
      m_prev = eff;
      ev = 0; nf = 0;
      if (v) begin
         case (eff)
            2'b00: ev = 1;
            2'b01: ev = ia;
            default: begin
               if (ia) begin
                  m_acc = (b == STA); m_pend = m_acc;
                  ev = m_acc && (eff == 2'b10);
               end else begin
                  ev = m_acc; nf = m_pend;
                  if (m_acc) m_pend = 0;
               end
            end
         endcase
      end
      return {ev, nf};
   endfunction

   task automatic step(input bit en, input logic [1:0] md, input bit v,
                       input bit ia, input logic [W-1:0] b, input string tag);
      logic [1:0] e;
      mp_en = en; mp_mode = md; rx_valid = v; rx_is_addr = ia; rx_byte = b;
      e = model(en, md, v, ia, b);
      @(negedge clk);
      vectors++;
      if (evt_valid !== e[1] ||
          (e[1] && (evt_byte !== b || evt_is_addr !== ia || evt_new_frame !== e[0]))) begin
         fails++;
         $display("FAIL %s: got v=%0b b=%h a=%0b nf=%0b, exp v=%0b b=%h a=%0b nf=%0b",
                  tag, evt_valid, evt_byte, evt_is_addr, evt_new_frame,
                  e[1], b, ia, e[0]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got hung run, exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // R11 reset state
      rx_valid = 1'b1; rx_byte = 8'h11;
      repeat (3) @(negedge clk);
      vectors++;
      if (evt_valid !== 1'b0) begin
         fails++;
         $display("FAIL R11: got v=%0b, exp v=0", evt_valid);
      end
      rst_n = 1'b1;
      step(1, 2'b10, 1, 0, 8'h22, "R11");
      // R1 bypass with enable off
      step(0, 2'b11, 1, 1, 8'h33, "R1");
      step(0, 2'b10, 1, 0, 8'h44, "R1");
      // R2 mode 00
      step(1, 2'b00, 1, 0, 8'h55, "R2");
      step(1, 2'b00, 1, 1, 8'h66, "R2");
      // R3 address only
      step(1, 2'b01, 1, 1, 8'h01, "R3");
      step(1, 2'b01, 1, 0, 8'h02, "R3");
      step(1, 2'b01, 0, 1, 8'h03, "R10");
      // R4 / R5 matching frame
      step(1, 2'b10, 1, 1, STA,   "R4");
      step(1, 2'b10, 1, 0, 8'hA0, "R5");
      step(1, 2'b10, 1, 0, 8'hA1, "R5");
      step(1, 2'b10, 0, 0, 8'hA2, "R10");
      // R7 rematch inside open frame, back to back
      step(1, 2'b10, 1, 1, STA,   "R7");
      step(1, 2'b10, 1, 1, STA,   "R7");
      step(1, 2'b10, 1, 0, 8'hB0, "R7");
      // R6 mismatch closes frame
      step(1, 2'b10, 1, 1, 8'h5B, "R6");
      step(1, 2'b10, 1, 0, 8'hB1, "R6");
      step(1, 2'b10, 1, 0, 8'hB2, "R6");
      // R8 data-only mode
      step(1, 2'b11, 1, 1, STA,   "R8");
      step(1, 2'b11, 1, 0, 8'hC0, "R8");
      step(1, 2'b11, 1, 0, 8'hC1, "R8");
      // R9 mode change mid frame with a data byte
      step(1, 2'b10, 1, 0, 8'hC2, "R9");
      step(1, 2'b10, 1, 1, STA,   "R9");
      step(0, 2'b10, 0, 0, 8'h00, "R9");
      step(1, 2'b10, 1, 0, 8'hC3, "R9");
      // random phase
      begin
         bit en = 1;
         logic [1:0] md = 2'b10;
         for (int i = 0; i < 6000; i++) begin
            bit v, ia;
            logic [W-1:0] b;
            if ($urandom % 40 == 0) md = 2'($urandom);
            if ($urandom % 60 == 0) en = ~en;
            v  = ($urandom % 4) != 0;
            ia = ($urandom % 5) == 0;
            b  = (ia && $urandom % 2) ? STA : W'($urandom);
            step(en, md, v, ia, b, "R10");
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule